// File: doc/BRIEF.md
# Configurable Programmable-Logic Macrocell Register

This block is the storage element of one programmable-logic macrocell. A data sum term is formed by OR-ing one universal and four regional product terms, and it feeds a single flip-flop. Static configuration bits choose between D-type loading and T-type toggling. They also choose whether the flip-flop is clocked by a bare clock product term or by a dedicated regional clock pin gated with that term. Individual preset and reset product terms force the flip-flop. The cell returns its state and that state's complement for the regional bus. A feedback mux can instead return the raw sum term, which lets an unused register serve as logic expansion.

The product terms arrive as plain input vectors. The block runs on a fast system clock and oversamples the derived register clock, acting on each 0-to-1 transition of it. The preset and reset terms are also sampled on the system clock. The configuration inputs are captured only while the block is held in reset, and they stay frozen after release.

Top module: `pld_macrocell`

## Requirements
- R1: In D mode (`cfg_toggle_i`=0), each rising transition of the selected register clock loads the sum term into `q_o`, as seen at the next system clock edge.
- R2: In T mode (`cfg_toggle_i`=1), a register clock transition inverts `q_o` when the sum term is 1 and leaves it unchanged when the sum term is 0.
- R3: In product-term clock mode (`cfg_sync_clk_i`=0), the register clock is `clk_pt_i` alone, and `rclk_pin_i` has no effect on `q_o`.
- R4: In pin clock mode (`cfg_sync_clk_i`=1), the register clock is `rclk_pin_i` AND `clk_pt_i`. A transition of either input while the other is low does not clock the register.
- R5: A high `preset_pt_i` sets `q_o` to 1 at the next system clock edge, whatever the register clock is doing.
- R6: A high `reset_pt_i` clears `q_o` to 0 at the next system clock edge, and it takes priority over `preset_pt_i`.
- R7: While `rst_n` is low, `q_o` is 0 and `q_n_o` is 1. The configuration inputs are captured only during reset, and a change to them after release has no effect.
- R8: With `cfg_fb_sum_i`=1, `fb_o` carries the sum term. With `cfg_fb_sum_i`=0, `fb_o` carries `q_o`.
- R9: The sum term is 1 when any one of the universal or regional product terms is 1, and 0 when all of them are 0.
- R10: `q_n_o` is always the complement of `q_o`.
- R11: Holding the register clock high does not clock the register again. Only a 0-to-1 change counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low reset, synchronous release; power-up clear |
| cfg_toggle_i | input | 1 | 1 selects T-type, 0 selects D-type (captured in reset) |
| cfg_sync_clk_i | input | 1 | 1 gates the regional clock pin with the clock term (captured in reset) |
| cfg_fb_sum_i | input | 1 | 1 returns the sum term on feedback, 0 returns Q (captured in reset) |
| uni_pt_i | input | N_UNI | Universal product terms of the data sum |
| reg_pt_i | input | N_REG | Regional product terms of the data sum |
| clk_pt_i | input | 1 | Clock product term |
| rclk_pin_i | input | 1 | Dedicated regional clock pin |
| preset_pt_i | input | 1 | Preset product term |
| reset_pt_i | input | 1 | Reset product term |
| q_o | output | 1 | Register state |
| q_n_o | output | 1 | Complement of the register state |
| fb_o | output | 1 | Selected feedback value for the regional bus |

## Verification
The assertions assume that every product term and the regional clock pin are already synchronous to the system clock. They also assume each input holds for at least one system clock, so that each 0-to-1 change of the derived clock is seen exactly once. The bench changes every input on the falling system clock edge and keeps the clock term and the pin low when reset is released. This keeps the power-up clear free of a spurious first edge and lets the edge detector start from a known low level.

// File: rtl/pld_mc_pkg.sv
`timescale 1ns/1ps
package pld_mc_pkg;

  typedef struct packed {
    logic toggle;    // T-type when set
    logic sync_clk;  // regional pin gated by clock term
    logic fb_sum;    // feedback carries the sum term
  } mc_cfg_t;

  // Next register value on a register clock transition.
  function automatic logic f_next_q(input logic toggle, input logic q, input logic d);
    return toggle ? (q ^ d) : d;
  endfunction

  // Level of the derived register clock.
  function automatic logic f_clk_level(input logic sync_clk, input logic pin, input logic pt);
    return sync_clk ? (pin & pt) : pt;
  endfunction

endpackage

// File: rtl/pld_mc_sum_term.sv
`timescale 1ns/1ps
module pld_mc_sum_term #(
  parameter int N_UNI = 1,
  parameter int N_REG = 4
) (
  input  logic [N_UNI-1:0] uni_pt,
  input  logic [N_REG-1:0] reg_pt,
  output logic             sum
);
  localparam int N_PT = N_UNI + N_REG;

  logic [N_PT-1:0] terms;
  logic [N_PT:0]   acc;

  assign terms  = {uni_pt, reg_pt};
  assign acc[0] = 1'b0;

  for (genvar i = 0; i < N_PT; i++) begin : g_or
    assign acc[i+1] = acc[i] | terms[i];
  end

  assign sum = acc[N_PT];
endmodule

// File: rtl/pld_mc_clk_sel.sv
`timescale 1ns/1ps
module pld_mc_clk_sel
  import pld_mc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_clk,
  input  logic pin,
  input  logic pt,
  output logic clk_rise
);
  logic lvl;
  logic lvl_prev;

  assign lvl = f_clk_level(sync_clk, pin, pt);

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= lvl;
  end

  assign clk_rise = lvl & ~lvl_prev;

  // R4: with pin clocking, a low pin blocks any register clock
  p_pin_gates_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_clk && !pin) |-> !clk_rise);
endmodule

// File: rtl/pld_mc_reg_core.sv
`timescale 1ns/1ps
module pld_mc_reg_core
  import pld_mc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic toggle,
  input  logic d,
  input  logic clk_rise,
  input  logic preset,
  input  logic reset,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        q <= 1'b0;
    else if (reset)    q <= 1'b0;
    else if (preset)   q <= 1'b1;
    else if (clk_rise) q <= f_next_q(toggle, q, d);
  end

  p_reset_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reset |=> !q);

  p_preset_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (preset && !reset) |=> q);

  p_no_edge_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_rise && !preset && !reset) |=> $stable(q));

  p_d_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_rise && !toggle && !preset && !reset) |=> (q == $past(d)));

  p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_rise && toggle && d && !preset && !reset) |=> (q != $past(q)));
endmodule

// File: rtl/pld_macrocell.sv
`timescale 1ns/1ps
module pld_macrocell
  import pld_mc_pkg::*;
#(
  parameter int N_UNI = 1,
  parameter int N_REG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_toggle_i,
  input  logic             cfg_sync_clk_i,
  input  logic             cfg_fb_sum_i,
  input  logic [N_UNI-1:0] uni_pt_i,
  input  logic [N_REG-1:0] reg_pt_i,
  input  logic             clk_pt_i,
  input  logic             rclk_pin_i,
  input  logic             preset_pt_i,
  input  logic             reset_pt_i,
  output logic             q_o,
  output logic             q_n_o,
  output logic             fb_o
);
  mc_cfg_t cfg_q;
  logic    sum_d;
  logic    clk_rise;

  // Configuration is captured only while reset is held (R7).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.toggle   <= cfg_toggle_i;
      cfg_q.sync_clk <= cfg_sync_clk_i;
      cfg_q.fb_sum   <= cfg_fb_sum_i;
    end
  end

  pld_mc_sum_term #(.N_UNI(N_UNI), .N_REG(N_REG)) u_sum (
    .uni_pt (uni_pt_i),
    .reg_pt (reg_pt_i),
    .sum    (sum_d)
  );

  pld_mc_clk_sel u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_clk (cfg_q.sync_clk),
    .pin      (rclk_pin_i),
    .pt       (clk_pt_i),
    .clk_rise (clk_rise)
  );

  pld_mc_reg_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .toggle   (cfg_q.toggle),
    .d        (sum_d),
    .clk_rise (clk_rise),
    .preset   (preset_pt_i),
    .reset    (reset_pt_i),
    .q        (q_o)
  );

  assign q_n_o = ~q_o;
  assign fb_o  = cfg_q.fb_sum ? sum_d : q_o;

  // R8: with Q feedback the bus follows the register across clock cycles
  p_fb_tracks_q_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.fb_sum && $stable(q_o)) |-> (fb_o == q_o));
endmodule

// File: tb/pld_macrocell_bench.sv
`timescale 1ns/1ps
module pld_macrocell_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_toggle = 1'b0, cfg_sync = 1'b0, cfg_fb = 1'b0;
  logic [0:0] uni = '0;
  logic [3:0] regp = '0;
  logic       cpt = 1'b0, pin = 1'b0, pre = 1'b0, rst = 1'b0;
  logic       q, qn, fb;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pld_macrocell u_pld_macrocell (
    .clk(clk), .rst_n(rst_n),
    .cfg_toggle_i(cfg_toggle), .cfg_sync_clk_i(cfg_sync), .cfg_fb_sum_i(cfg_fb),
    .uni_pt_i(uni), .reg_pt_i(regp), .clk_pt_i(cpt), .rclk_pin_i(pin),
    .preset_pt_i(pre), .reset_pt_i(rst),
    .q_o(q), .q_n_o(qn), .fb_o(fb)
  );

  // Vector: [9]=universal term, [8:5]=regional terms, [4]=clock term,
  // [3]=regional pin, [2]=preset, [1]=reset, [0]=expected Q.
  // Walked in D mode, product-term clocking, Q feedback.
  localparam int NV = 14;
  localparam logic [9:0] VEC [NV] = '{
    10'b0_0000_0_0_0_0_0,
    10'b1_0000_1_0_0_0_1,
    10'b0_0000_1_0_0_0_1,
    10'b0_0000_0_0_0_0_1,
    10'b0_0100_1_0_0_0_1,
    10'b0_0000_0_0_0_0_1,
    10'b0_0000_1_0_0_0_0,
    10'b1_0000_0_1_0_0_0,
    10'b0_0000_0_0_1_0_1,
    10'b0_0000_0_0_1_1_0,
    10'b0_0001_1_0_0_0_1,
    10'b0_0000_1_0_0_1_0,
    10'b0_0000_0_0_0_0_0,
    10'b0_0010_1_0_0_0_1
  };

  function automatic string tag_of(input int i);
    case (i)
      2:       return "R11";
      4:       return "R9";
      7:       return "R3";
      8:       return "R5";
      9, 11:   return "R6";
      13:      return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic u, input logic [3:0] r, input logic c,
                       input logic p, input logic ps, input logic rs);
    @(negedge clk);
    uni[0] = u; regp = r; cpt = c; pin = p; pre = ps; rst = rs;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic t, input logic s, input logic f);
    @(negedge clk);
    rst_n = 1'b0; cfg_toggle = t; cfg_sync = s; cfg_fb = f;
    uni = '0; regp = '0; cpt = 1'b0; pin = 1'b0; pre = 1'b0; rst = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R7", q, 1'b0);
    check("R7", qn, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0, 1'b0, 1'b0);

    // Table walk: D mode, product-term clock, Q feedback
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][9], VEC[i][8:5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
      check(tag_of(i), q, VEC[i][0]);
      check("R10", qn, ~VEC[i][0]);
      check("R8", fb, VEC[i][0]);
    end

    // R7: reset clears a set register
    do_reset(1'b1, 1'b0, 1'b0);

    // R2: T mode
    drive(1'b1, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0); check("R2", q, 1'b1);
    drive(1'b1, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0); check("R2", q, 1'b1);
    drive(1'b1, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0); check("R2", q, 1'b0);
    drive(1'b1, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0); check("R2", q, 1'b0);
    drive(1'b1, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0); check("R2", q, 1'b1);
    drive(1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0); check("R2", q, 1'b1);
    drive(1'b0, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0); check("R2", q, 1'b1);

    // R4: pin clock mode, D type
    do_reset(1'b0, 1'b1, 1'b0);
    drive(1'b1, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0); check("R4", q, 1'b0);
    drive(1'b1, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b0); check("R4", q, 1'b1);
    drive(1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0); check("R4", q, 1'b1);
    drive(1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0); check("R4", q, 1'b1);
    drive(1'b0, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b0); check("R4", q, 1'b0);

    // R7: configuration change after release is ignored
    cfg_sync = 1'b0;
    drive(1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0); check("R7", q, 1'b0);
    drive(1'b1, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0); check("R7", q, 1'b0);

    // R8: sum-term feedback
    do_reset(1'b0, 1'b0, 1'b1);
    drive(1'b0, 4'b0100, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8", fb, 1'b1); check("R8", q, 1'b0);
    drive(1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0); check("R8", fb, 1'b0);
    drive(1'b1, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R8", fb, 1'b1); check("R1", q, 1'b1);
    drive(1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8", fb, 1'b0); check("R10", qn, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule